// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block keeps the 64-bit compare value that supervisor software uses to schedule its next timer interrupt. A free-running 64-bit time input is compared against that value on every clock. The result drives the supervisor timer-pending bit, so software never writes the bit itself. It only moves the compare value into the past or the future.

The block sits beside the CSR file and owns two CSR addresses. It decides in the same cycle whether an access is legal. The decision depends on:

- the current privilege level;
- the counter-enable bit that exposes time to lower levels;
- the environment-config enable for the compare feature;
- whether the extension is present and a time source exists;
- the base width (32-bit or 64-bit).

On a 32-bit base the register is reached as two halves.

The block also filters the write mask of the interrupt-pending register. Machine-mode software then cannot override the hardware-owned timer-pending bits while the feature is enabled.

Top module: `stc_unit`

## Requirements
- R1: The compare register is reached at CSR address 0x14D (low, or full on a 64-bit base) and 0x15D (high half). A valid access to any other address gives csrIllegal=0 and csrRdata=0, and leaves the register unchanged.
- R2: When extEnable=0 or timeValid=0, any valid access to either address sets csrIllegal=1, whatever the privilege.
- R3: With extEnable=1 and timeValid=1, privLevel=2'b11 (machine) may always access 0x14D, and may access 0x15D subject to R5. The enable bits are ignored in machine mode.
- R4: Below machine mode, access needs both cntTmEn=1 and envStce=1, and also a privilege other than user (2'b00). Otherwise csrIllegal=1. Supervisor is 2'b01.
- R5: An access to 0x15D is illegal when isRv32=0.
- R6: With isRv32=1, a legal write to 0x14D replaces only bits 31:0, and a legal write to 0x15D replaces only bits 63:32, taken from csrWdata[31:0]. With isRv32=0, a legal write to 0x14D replaces all 64 bits. Writes take effect at the next clock edge.
- R7: Reads are combinational. On a 64-bit base, 0x14D returns all 64 bits. On a 32-bit base, 0x14D returns bits 31:0 zero-extended. 0x15D returns bits 63:32 zero-extended. An illegal access returns 0.
- R8: timerPending equals the unsigned comparison (compare <= timeNow) taken one clock edge earlier.
- R9: csrIllegal is returned in the cycle of the access, and an illegal access never changes the register.
- R10: ipWrMaskOut equals ipWrMaskIn, except that bits 5 (supervisor timer) and 6 (virtual supervisor timer) are forced to 0 when extEnable=1, envStce=1 and privLevel=2'b11.
- R11: Reset (rstN=0, asynchronous) clears the compare register to 0 and holds timerPending at 0. After reset, the compare value 0 makes timerPending 1 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extEnable | input | 1 | Timer-compare extension present |
| timeValid | input | 1 | A time source is attached |
| privLevel | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| cntTmEn | input | 1 | Counter-enable bit that exposes time below machine mode |
| envStce | input | 1 | Environment-config enable of the compare feature |
| isRv32 | input | 1 | Base width is 32 bits |
| timeNow | input | 64 | Free-running time value |
| csrValid | input | 1 | CSR access strobe |
| csrAddr | input | 12 | CSR address |
| csrWrite | input | 1 | Access is a write |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Read data (combinational) |
| csrIllegal | output | 1 | Access raises illegal-instruction (combinational) |
| ipWrMaskIn | input | 16 | Interrupt-pending write mask from the CSR file |
| ipWrMaskOut | output | 16 | Filtered interrupt-pending write mask |
| timerPending | output | 1 | Supervisor timer-pending bit |

## Verification
The bench first targets the comparison boundaries:

- compare equal to time must raise pending;
- compare one above time must clear it;
- a compare value with bit 63 set must stay pending-free against a time just below it. A signed comparison would fail this case.

On a 32-bit base, half writes are checked for leakage into the other half. A design that writes the full width would wipe the high half. Each enable and privilege combination is tried against a register with a known value. A permissive check would show up as a changed register, and an over-strict one as a legal access flagged illegal. The pending-mask filter is checked in and out of machine mode, because a filter that ignores the privilege would wrongly block supervisor-level writes.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [11:0] CSR_CMP_LO = 12'h14D;
  localparam logic [11:0] CSR_CMP_HI = 12'h15D;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrLo;    // 32-bit base, low half write
    logic wrHi;    // high half write
    logic wrAll;   // 64-bit base, full write
    logic rdLo32;  // low half read, zero-extended
    logic rdHi;    // high half read
    logic rdAll;   // full read
  } stc_strobe_t;
endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int IP_W      = 16,
  parameter int STIP_BIT  = 5,
  parameter int VSTIP_BIT = 6
) (
  input  logic              extEnable,
  input  logic              timeValid,
  input  logic [1:0]        privLevel,
  input  logic              cntTmEn,
  input  logic              envStce,
  input  logic              isRv32,
  input  logic              csrValid,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWrite,
  input  logic [IP_W-1:0]   ipWrMaskIn,
  output logic [IP_W-1:0]   ipWrMaskOut,
  output logic              csrIllegal,
  output stc_strobe_t       strb
);
  priv_e privCur;
  logic  isLo, isHi, hit;
  logic  baseOk, privOk, widthOk, accessOk, maskOn;

  assign privCur = priv_e'(privLevel);
  assign isLo    = (csrAddr == ADDR_W'(CSR_CMP_LO));
  assign isHi    = (csrAddr == ADDR_W'(CSR_CMP_HI));
  assign hit     = csrValid && (isLo || isHi);

  assign baseOk  = extEnable && timeValid;
  assign privOk  = (privCur == PRIV_M) ||
                   (cntTmEn && envStce && (privCur != PRIV_U));
  assign widthOk = isLo || isRv32;

  assign accessOk   = hit && baseOk && privOk && widthOk;
  assign csrIllegal = hit && !(baseOk && privOk && widthOk);

  always_comb begin
    strb        = '0;
    strb.wrLo   = accessOk && csrWrite && isLo && isRv32;
    strb.wrAll  = accessOk && csrWrite && isLo && !isRv32;
    strb.wrHi   = accessOk && csrWrite && isHi;
    strb.rdLo32 = accessOk && isLo && isRv32;
    strb.rdAll  = accessOk && isLo && !isRv32;
    strb.rdHi   = accessOk && isHi;
  end

  assign maskOn = extEnable && envStce && (privCur == PRIV_M);

  for (genvar b = 0; b < IP_W; b++) begin : g_mask
    if (b == STIP_BIT || b == VSTIP_BIT) begin : g_hw
      assign ipWrMaskOut[b] = ipWrMaskIn[b] && !maskOn;
    end else begin : g_sw
      assign ipWrMaskOut[b] = ipWrMaskIn[b];
    end
  end
endmodule

// File: rtl/stc_dpath.sv
module stc_dpath
  import stc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  stc_strobe_t       strb,
  input  logic [TIME_W-1:0] wdata,
  input  logic [TIME_W-1:0] timeNow,
  output logic [TIME_W-1:0] cmpQ,
  output logic [TIME_W-1:0] rdata,
  output logic              pending
);
  localparam int HALF_W = TIME_W / 2;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              loadHalf;
    logic [HALF_W-1:0] srcHalf;
    logic [HALF_W-1:0] halfQ;

    if (h == 0) begin : g_lo
      assign loadHalf = strb.wrAll || strb.wrLo;
      assign srcHalf  = wdata[HALF_W-1:0];
    end else begin : g_hi
      assign loadHalf = strb.wrAll || strb.wrHi;
      assign srcHalf  = strb.wrAll ? wdata[TIME_W-1:HALF_W] : wdata[HALF_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         halfQ <= '0;
      else if (loadHalf) halfQ <= srcHalf;
    end

    assign cmpQ[h*HALF_W +: HALF_W] = halfQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= (cmpQ <= timeNow);
  end

  always_comb begin
    rdata = '0;
    if (strb.rdAll)  rdata = cmpQ;
    if (strb.rdLo32) rdata = {{HALF_W{1'b0}}, cmpQ[HALF_W-1:0]};
    if (strb.rdHi)   rdata = {{HALF_W{1'b0}}, cmpQ[TIME_W-1:HALF_W]};
  end
endmodule

// File: rtl/stc_unit.sv
module stc_unit
  import stc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 12,
  parameter int IP_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extEnable,
  input  logic              timeValid,
  input  logic [1:0]        privLevel,
  input  logic              cntTmEn,
  input  logic              envStce,
  input  logic              isRv32,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              csrValid,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWrite,
  input  logic [TIME_W-1:0] csrWdata,
  output logic [TIME_W-1:0] csrRdata,
  output logic              csrIllegal,
  input  logic [IP_W-1:0]   ipWrMaskIn,
  output logic [IP_W-1:0]   ipWrMaskOut,
  output logic              timerPending
);
  stc_strobe_t       strb;
  logic [TIME_W-1:0] cmpValue;

  stc_ctrl #(.ADDR_W(ADDR_W), .IP_W(IP_W)) u_ctrl (
    .extEnable(extEnable), .timeValid(timeValid), .privLevel(privLevel),
    .cntTmEn(cntTmEn), .envStce(envStce), .isRv32(isRv32),
    .csrValid(csrValid), .csrAddr(csrAddr), .csrWrite(csrWrite),
    .ipWrMaskIn(ipWrMaskIn), .ipWrMaskOut(ipWrMaskOut),
    .csrIllegal(csrIllegal), .strb(strb)
  );

  stc_dpath #(.TIME_W(TIME_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(csrWdata),
    .timeNow(timeNow), .cmpQ(cmpValue), .rdata(csrRdata),
    .pending(timerPending)
  );
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 12,
  parameter int IP_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              extEnable,
  input logic              timeValid,
  input logic [1:0]        privLevel,
  input logic              envStce,
  input logic              isRv32,
  input logic [TIME_W-1:0] timeNow,
  input logic              csrValid,
  input logic [ADDR_W-1:0] csrAddr,
  input logic              csrIllegal,
  input logic [IP_W-1:0]   ipWrMaskOut,
  input logic              timerPending,
  input logic [TIME_W-1:0] cmpValue
);
  logic ourAddr;
  assign ourAddr = (csrAddr == ADDR_W'(12'h14D)) || (csrAddr == ADDR_W'(12'h15D));

  assert_pending_cmp_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> timerPending == ($past(cmpValue) <= $past(timeNow)));

  assert_no_ext_illegal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && ourAddr && !(extEnable && timeValid)) |-> csrIllegal);

  assert_machine_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrAddr == ADDR_W'(12'h14D) && extEnable && timeValid &&
     privLevel == 2'b11) |-> !csrIllegal);

  assert_hi_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrAddr == ADDR_W'(12'h15D) && !isRv32) |-> csrIllegal);

  assert_illegal_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrIllegal) |=> $stable(cmpValue));

  assert_other_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !ourAddr) |-> !csrIllegal);

  assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (extEnable && envStce && privLevel == 2'b11) |-> (ipWrMaskOut[6:5] == 2'b00));
endmodule

bind stc_unit stc_checker #(.TIME_W(TIME_W), .ADDR_W(ADDR_W), .IP_W(IP_W)) u_stc_checker (
  .clk(clk), .rstN(rstN), .extEnable(extEnable), .timeValid(timeValid),
  .privLevel(privLevel), .envStce(envStce), .isRv32(isRv32),
  .timeNow(timeNow), .csrValid(csrValid), .csrAddr(csrAddr),
  .csrIllegal(csrIllegal), .ipWrMaskOut(ipWrMaskOut),
  .timerPending(timerPending), .cmpValue(cmpValue)
);

// File: tb/stc_unit_bench.sv
module stc_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extEnable = 1'b1, timeValid = 1'b1;
  logic [1:0]  privLevel = 2'b11;
  logic        cntTmEn = 1'b0, envStce = 1'b0, isRv32 = 1'b0;
  logic [63:0] timeNow = 64'd100;
  logic        csrValid = 1'b0, csrWrite = 1'b0;
  logic [11:0] csrAddr = 12'h0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic        csrIllegal;
  logic [15:0] ipWrMaskIn = '0;
  logic [15:0] ipWrMaskOut;
  logic        timerPending;

  int total = 0;
  int bad = 0;
  logic [63:0] lastRd;
  logic        lastIll;

  always #2 clk = ~clk;

  stc_unit u_stc_unit (
    .clk(clk), .rstN(rstN), .extEnable(extEnable), .timeValid(timeValid),
    .privLevel(privLevel), .cntTmEn(cntTmEn), .envStce(envStce),
    .isRv32(isRv32), .timeNow(timeNow), .csrValid(csrValid),
    .csrAddr(csrAddr), .csrWrite(csrWrite), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .csrIllegal(csrIllegal), .ipWrMaskIn(ipWrMaskIn),
    .ipWrMaskOut(ipWrMaskOut), .timerPending(timerPending)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: driven at a falling edge, captured at the next rising edge
  task automatic access(input logic [11:0] a, input logic we, input logic [63:0] d);
    @(negedge clk);
    csrValid = 1'b1; csrAddr = a; csrWrite = we; csrWdata = d;
    #1;
    lastRd = csrRdata; lastIll = csrIllegal;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] p, input logic tm, input logic st, input logic r32);
    privLevel = p; cntTmEn = tm; envStce = st; isRv32 = r32;
  endtask

  task automatic readFull(output logic [63:0] v);
    logic [1:0] sp; logic st, tm, r32;
    sp = privLevel; st = envStce; tm = cntTmEn; r32 = isRv32;
    setMode(2'b11, 1'b0, 1'b0, 1'b0);
    access(12'h14D, 1'b0, '0);
    v = lastRd;
    setMode(sp, tm, st, r32);
  endtask

  task automatic testReset();
    logic [63:0] v;
    @(negedge clk); #1;
    check("R11 pending held low in reset", {63'b0, timerPending}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 pending after reset with cmp 0", {63'b0, timerPending}, 64'd1);
    readFull(v);
    check("R11 register zero after reset", v, 64'd0);
  endtask

  task automatic testCompare64();
    logic [63:0] v;
    setMode(2'b11, 1'b0, 1'b0, 1'b0);
    timeNow = 64'd1000;
    access(12'h14D, 1'b1, 64'd1001);
    check("R9 legal machine write not illegal", {63'b0, lastIll}, 64'd0);
    @(negedge clk);
    check("R8 cmp one above time clears pending", {63'b0, timerPending}, 64'd0);
    readFull(v);
    check("R7 R6 full read back on 64-bit base", v, 64'd1001);
    timeNow = 64'd1001;
    @(negedge clk);
    check("R8 cmp equal to time sets pending", {63'b0, timerPending}, 64'd1);
    access(12'h14D, 1'b1, 64'h8000_0000_0000_0000);
    timeNow = 64'h7FFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check("R8 unsigned compare top bit", {63'b0, timerPending}, 64'd0);
    access(12'h14D, 1'b1, '1);
    timeNow = '1;
    @(negedge clk);
    check("R8 all ones equal", {63'b0, timerPending}, 64'd1);
    timeNow = 64'd1000;
  endtask

  task automatic testHalves32();
    logic [63:0] v;
    setMode(2'b11, 1'b0, 1'b0, 1'b0);
    access(12'h14D, 1'b1, 64'h1111_2222_3333_4444);
    setMode(2'b11, 1'b0, 1'b0, 1'b1);
    access(12'h14D, 1'b1, 64'hFFFF_FFFF_AAAA_5555);
    readFull(v);
    check("R6 low write keeps high half", v, 64'h1111_2222_AAAA_5555);
    access(12'h15D, 1'b1, 64'hEEEE_EEEE_0BAD_F00D);
    readFull(v);
    check("R6 high write keeps low half", v, 64'h0BAD_F00D_AAAA_5555);
    access(12'h15D, 1'b0, '0);
    check("R7 high read zero-extended", lastRd, 64'h0000_0000_0BAD_F00D);
    access(12'h14D, 1'b0, '0);
    check("R7 low read zero-extended on 32-bit", lastRd, 64'h0000_0000_AAAA_5555);
  endtask

  task automatic testIllegal();
    logic [63:0] v;
    setMode(2'b11, 1'b0, 1'b0, 1'b0);
    access(12'h14D, 1'b1, 64'h0000_0000_0000_7777);
    access(12'h15D, 1'b1, 64'h1234);
    check("R5 high address illegal on 64-bit", {63'b0, lastIll}, 64'd1);
    check("R7 illegal read returns zero", lastRd, 64'd0);
    readFull(v);
    check("R9 illegal high write leaves register", v, 64'h7777);
    extEnable = 1'b0;
    access(12'h14D, 1'b1, 64'h5);
    check("R2 extension off illegal", {63'b0, lastIll}, 64'd1);
    extEnable = 1'b1; timeValid = 1'b0;
    access(12'h14D, 1'b1, 64'h6);
    check("R2 no time source illegal", {63'b0, lastIll}, 64'd1);
    timeValid = 1'b1;
    readFull(v);
    check("R9 R2 blocked writes left register", v, 64'h7777);
    access(12'h14E, 1'b1, 64'h9);
    check("R1 other address not illegal", {63'b0, lastIll}, 64'd0);
    check("R1 other address reads zero", lastRd, 64'd0);
    readFull(v);
    check("R1 other address write ignored", v, 64'h7777);
  endtask

  task automatic testPrivilege();
    logic [63:0] v;
    setMode(2'b01, 1'b1, 1'b1, 1'b0);
    access(12'h14D, 1'b1, 64'h42);
    check("R4 supervisor with both enables legal", {63'b0, lastIll}, 64'd0);
    readFull(v);
    check("R4 supervisor write landed", v, 64'h42);
    setMode(2'b01, 1'b0, 1'b1, 1'b0);
    access(12'h14D, 1'b1, 64'h43);
    check("R4 supervisor without counter enable", {63'b0, lastIll}, 64'd1);
    setMode(2'b01, 1'b1, 1'b0, 1'b0);
    access(12'h14D, 1'b1, 64'h44);
    check("R4 supervisor without config enable", {63'b0, lastIll}, 64'd1);
    setMode(2'b00, 1'b1, 1'b1, 1'b0);
    access(12'h14D, 1'b1, 64'h45);
    check("R4 user level illegal", {63'b0, lastIll}, 64'd1);
    readFull(v);
    check("R4 R9 denied writes left register", v, 64'h42);
    setMode(2'b11, 1'b0, 1'b0, 1'b1);
    access(12'h15D, 1'b1, 64'h3);
    check("R3 machine ignores enables on high half", {63'b0, lastIll}, 64'd0);
    readFull(v);
    check("R3 machine high write landed", v, 64'h0000_0003_0000_0042);
  endtask

  task automatic testMask();
    ipWrMaskIn = 16'hFFFF;
    setMode(2'b11, 1'b0, 1'b1, 1'b0);
    #1;
    check("R10 machine with config enable clears bits 5 and 6",
          {48'b0, ipWrMaskOut}, 64'h0000_0000_0000_FF9F);
    setMode(2'b01, 1'b1, 1'b1, 1'b0);
    #1;
    check("R10 supervisor mask passes", {48'b0, ipWrMaskOut}, 64'hFFFF);
    setMode(2'b11, 1'b0, 1'b0, 1'b0);
    #1;
    check("R10 config enable off passes", {48'b0, ipWrMaskOut}, 64'hFFFF);
    ipWrMaskIn = 16'h0000;
  endtask

  initial begin
    testReset();
    testCompare64();
    testHalves32();
    testIllegal();
    testPrivilege();
    testMask();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule